// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block collects single-cycle event pulses from a serial channel into two 8-bit interrupt status registers and drives one interrupt line. Each status register has a companion mask register. An event pulse is recorded in its status bit when the matching mask bit is clear. It is also recorded when a visibility control bit is set, even if the bit is masked. Only unmasked events can raise the interrupt. Software reads a status register to learn which events happened, and the read clears it.

Each status register and its mask share one address. A read returns the status and clears it. A write loads the mask. A third address holds the visibility control bit. The interrupt output is a register. An unmasked event sets it to the OR of (status AND NOT mask) over both registers, taken after that event is recorded. A clearing read can only lower it. A mask write alone leaves it unchanged.

Top module: `irq_status_unit`

## Requirements
- R1: In status register 0, each bit stands for one event, from bit 7 down to bit 0: transmit character detected, timeout, parity error, framing error, PLL lost, carrier-detect change, receive overflow, receive pool full. A pulse on `evt0_i[k]` is reported in bit k of register 0.
- R2: Each event input vector (`evt0_i` for register 0, `evt1_i` for register 1) has at most one bit set in any cycle.
- R3: An event whose mask bit is 0 sets its status bit at the next clock edge.
- R4: An event whose mask bit is 1 sets its status bit only when the visibility bit (bit 0 at address 2) is 1. When the visibility bit is 0, the event leaves no trace.
- R5: A masked event never raises `irq_o`. In the cycle after an unmasked event, `irq_o` equals the OR of (status AND NOT mask) over both registers.
- R6: `irq_o` changes only after an unmasked event or after a status read. A status read can only lower it. A mask write on its own does not change it.
- R7: Address 0 is status/mask 0 and address 1 is status/mask 1. A read returns the status on `bus_rdata_o` one cycle later. A write loads the mask. Address 2 reads and writes the visibility bit in bit 0. Address 3 reads as 0 and ignores writes.
- R8: A status read returns the value held before that cycle's events and clears the register at the same edge.
- R9: An event that arrives in the same cycle as a clearing read of its register is kept in the status after the read.
- R10: Reset sets all status bits to 0, all mask bits to 1, the visibility bit to 0, `irq_o` to 0 and `bus_rdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt0_i | input | 8 | One-hot event pulses for status register 0 |
| evt1_i | input | 8 | One-hot event pulses for status register 1 |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench fires a masked event while the visibility bit is both off and on. A design that ignored the visibility bit would drop the event or record it at the wrong time. A design that let masked events drive the line would raise `irq_o` when it should stay low. Next, the bench unmasks a bit whose status is already pending. A design that recomputes the interrupt on every mask change would raise `irq_o` before any new unmasked event arrives. Last, the bench fires an event in the same cycle as a clearing read of its register. A design with the wrong priority would either lose the event or return it in that read's data.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int NREG   = 2;

  localparam logic [ADDR_W-1:0] A_STAT0 = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG   = 2'd2;

  // Bit positions of status register 0; a neighbour decodes these.
  typedef enum int {
    EV_RX_POOL_FULL = 0,
    EV_RX_OVERFLOW  = 1,
    EV_CD_CHANGE    = 2,
    EV_PLL_LOST     = 3,
    EV_FRAME_ERR    = 4,
    EV_PARITY_ERR   = 5,
    EV_TIMEOUT      = 6,
    EV_TX_CHAR      = 7
  } ev0_bit_e;

  localparam int CFG_VIS_BIT = 0;
endpackage

// File: rtl/isu_status_reg.sv
module isu_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         vis_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_next_o,
  output logic         hit_o
);
  logic [W-1:0] status_q, mask_q, set_v, status_d;

  always_comb begin
    set_v       = evt_i & (vis_i ? {W{1'b1}} : ~mask_q);
    status_d    = (rd_clr_i ? {W{1'b0}} : status_q) | set_v;
    pend_next_o = status_d & ~mask_q;
    hit_o       = |(evt_i & ~mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

  p_evt_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_i));

  p_unmasked_sets_r3: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & ~mask_q) != '0) |=>
      ((status_q & $past(evt_i & ~mask_q)) == $past(evt_i & ~mask_q)));

  p_masked_hidden_r4: assert property (@(posedge clk) disable iff (rst)
    (!vis_i && ((evt_i & mask_q & ~status_q) != '0)) |=>
      ((status_q & $past(evt_i & mask_q & ~status_q)) == '0));

  p_event_kept_on_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && ((evt_i & ~mask_q) != '0)) |=>
      (status_o == $past(evt_i & ~mask_q)));

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '1));
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit_i,
  input  logic         clr_i,
  input  logic         pend_any_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    if (|hit_i)     irq_d = pend_any_i;
    else if (clr_i) irq_d = irq_q & pend_any_i;
    else            irq_d = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_i == '0 && !clr_i) |=> $stable(irq_o));

  p_no_rise_without_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_i == '0) |=> !$rose(irq_o));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt0_i,
  input  logic [DW-1:0] evt1_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  localparam int NR = NREG;

  logic [NR-1:0][DW-1:0] evt_v, status_v, mask_v, pend_v;
  logic [NR-1:0]         hit_v, rd_v, wr_v;
  logic                  vis_q, pend_any, clr_any;
  logic [DW-1:0]         rdata_q, rdata_d;

  assign evt_v[0] = evt0_i;
  assign evt_v[1] = evt1_i;

  for (genvar g = 0; g < NR; g++) begin : g_reg
    assign rd_v[g] = bus_re_i && (bus_addr_i == AW'(g));
    assign wr_v[g] = bus_we_i && (bus_addr_i == AW'(g));
    isu_status_reg #(.W(DW)) i_reg (
      .clk          (clk),
      .rst          (rst),
      .evt_i        (evt_v[g]),
      .vis_i        (vis_q),
      .mask_we_i    (wr_v[g]),
      .mask_wdata_i (bus_wdata_i),
      .rd_clr_i     (rd_v[g]),
      .status_o     (status_v[g]),
      .mask_o       (mask_v[g]),
      .pend_next_o  (pend_v[g]),
      .hit_o        (hit_v[g])
    );
  end

  always_comb begin
    pend_any = 1'b0;
    for (int i = 0; i < NR; i++) pend_any = pend_any | (|pend_v[i]);
    clr_any = |rd_v;
  end

  isu_irq_gen #(.N(NR)) i_irq (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit_v),
    .clr_i      (clr_any),
    .pend_any_i (pend_any),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_addr_i == A_STAT0)     rdata_d = status_v[0];
    else if (bus_addr_i == A_STAT1) rdata_d = status_v[1];
    else if (bus_addr_i == A_CFG)   rdata_d[CFG_VIS_BIT] = vis_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_we_i && bus_addr_i == A_CFG) vis_q <= bus_wdata_i[CFG_VIS_BIT];
      if (bus_re_i) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  p_irq_matches_pending_r5: assert property (@(posedge clk) disable iff (rst)
    ((|hit_v) && !bus_we_i) |=>
      (irq_o == (|((status_v[0] & ~mask_v[0]) | (status_v[1] & ~mask_v[1])))));

  p_read_returns_status_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_re_i && bus_addr_i == A_STAT0) |=> (bus_rdata_o == $past(status_v[0])));

  p_reset_outputs_r10: assert property (@(posedge clk)
    rst |=> (!irq_o && bus_rdata_o == '0));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt0 = '0, evt1 = '0, wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst), .evt0_i(evt0), .evt1_i(evt1),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {we, re, addr, wdata, ev0, ev1, chk_rd, exp_rd, exp_irq}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b0,1'b0,2'd0,8'h00,8'h20,8'h00,1'b0,8'h00,1'b0}, // 0  R5 masked, hidden
    {1'b0,1'b1,2'd0,8'h00,8'h00,8'h00,1'b1,8'h00,1'b0}, // 1  R4 nothing recorded
    {1'b1,1'b0,2'd0,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0}, // 2  R7 unmask reg0
    {1'b0,1'b0,2'd0,8'h00,8'h20,8'h00,1'b0,8'h00,1'b1}, // 3  R3 R5 unmasked
    {1'b0,1'b1,2'd0,8'h00,8'h00,8'h00,1'b1,8'h20,1'b0}, // 4  R8 read clears
    {1'b1,1'b0,2'd2,8'h01,8'h00,8'h00,1'b0,8'h00,1'b0}, // 5  R7 vis on
    {1'b0,1'b0,2'd0,8'h00,8'h00,8'h04,1'b0,8'h00,1'b0}, // 6  R4 masked visible
    {1'b0,1'b1,2'd1,8'h00,8'h00,8'h00,1'b1,8'h04,1'b0}, // 7  R4 recorded
    {1'b0,1'b0,2'd0,8'h00,8'h00,8'h01,1'b0,8'h00,1'b0}, // 8  R5 no irq
    {1'b1,1'b0,2'd1,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0}, // 9  R6 mask write only
    {1'b0,1'b0,2'd0,8'h00,8'h80,8'h00,1'b0,8'h00,1'b1}, // 10 R5 both regs
    {1'b0,1'b1,2'd1,8'h00,8'h00,8'h00,1'b1,8'h01,1'b1}, // 11 R6 reg0 still pending
    {1'b0,1'b1,2'd0,8'h00,8'h02,8'h00,1'b1,8'h80,1'b1}, // 12 R9 R8 collide
    {1'b0,1'b1,2'd0,8'h00,8'h00,8'h00,1'b1,8'h02,1'b0}, // 13 R9 kept
    {1'b0,1'b1,2'd2,8'h00,8'h00,8'h00,1'b1,8'h01,1'b0}, // 14 R7 cfg read
    {1'b1,1'b0,2'd2,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0}, // 15 R7 vis off
    {1'b1,1'b0,2'd0,8'hFF,8'h00,8'h00,1'b0,8'h00,1'b0}, // 16 R7 mask all
    {1'b0,1'b0,2'd0,8'h00,8'h01,8'h00,1'b0,8'h00,1'b0}, // 17 R4 hidden again
    {1'b0,1'b1,2'd0,8'h00,8'h00,8'h00,1'b1,8'h00,1'b0}  // 18 R4 nothing
  };
  localparam int VREQ [NVEC] = '{5,4,7,3,8,7,4,4,5,6,5,6,9,9,7,7,7,4,4};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [7:0] d, input logic [7:0] e0, input logic [7:0] e1);
    we = w; re = r; addr = a; wdata = d; evt0 = e0; evt1 = e1;
    @(negedge clk);
    we = 1'b0; re = 1'b0; evt0 = '0; evt1 = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(rdata == 8'h00, "R10 rdata", rdata, 0);
    cyc(1'b0, 1'b1, 2'd2, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h00, "R10 vis", rdata, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [37:0] x;
      x = VEC[v];
      cyc(x[37], x[36], x[35:34], x[33:26], x[25:18], x[17:10]);
      if (x[9]) chk(rdata == x[8:1], $sformatf("R%0d vec %0d rdata", VREQ[v], v), rdata, x[8:1]);
      chk(irq == x[0], $sformatf("R%0d vec %0d irq", VREQ[v], v), irq, x[0]);
    end

    // R1 layout of register 0: each event lands on its own bit
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00);
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 1'b0, 2'd0, 8'h00, 8'(1 << b), 8'h00);
      cyc(1'b0, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
      chk(rdata == 8'(1 << b), $sformatf("R1 bit %0d", b), rdata, 1 << b);
    end
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 8'(1 << isu_pkg::EV_PARITY_ERR), 8'h00);
    cyc(1'b0, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h20, "R1 parity", rdata, 8'h20);

    // R10 reset in mid operation
    cyc(1'b1, 1'b0, 2'd2, 8'h01, 8'h00, 8'h00);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 8'h10, 8'h00);
    chk(irq == 1'b1, "R3 before reset", irq, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 8'h10, 8'h00);
    chk(irq == 1'b0, "R10 mask set", irq, 0);
    cyc(1'b0, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h00, "R10 status and vis clear", rdata, 0);
    cyc(1'b0, 1'b1, 2'd2, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h00, "R10 vis cleared", rdata, 0);
    // R7 unused address
    cyc(1'b1, 1'b0, 2'd3, 8'hFF, 8'h00, 8'h00);
    cyc(1'b0, 1'b1, 2'd3, 8'h00, 8'h00, 8'h00);
    chk(rdata == 8'h00, "R7 addr3", rdata, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule